// File: doc/BRIEF.md
# Serial Register-File Slave with Write Lock

This block lets an external host reach a 128-byte register space over a four-wire serial link. The host raises an active-high select line and shifts bytes in, MSB first. The first byte of every transaction is a command. Its top bit chooses write (1) or read (0), and its low seven bits give the starting address. Every later byte goes to, or comes from, the next address in turn. The address steps by one after each data byte and wraps from 0x7F back to 0x00.

The serial inputs are brought into the block's own clock domain through synchronisers, and the edges are then detected there. The block captures the clock's idle level when select rises. From that level it decides which edge is leading and which is trailing, so it serves both clock polarities with the second-edge sampling phase. Time bytes (0x00 to 0x06) and alarm bytes (0x07 to 0x0E) belong to a neighbouring timekeeping block. The time bytes are read from a snapshot, and writes to these bytes are forwarded as one-cycle pulses. The block itself holds the control register (0x0F), the charger setting (0x11) and a 96-byte user RAM (0x20 to 0x7F). Status (0x10) reads the neighbour's two alarm flags, and writes to it are forwarded so the neighbour can clear them.

Top module: `spi_regfile_slave`

## Requirements
- R1: A transaction begins when cs rises. Its first byte, sent MSB first, is the command: bit 7 = 1 selects write, bit 7 = 0 selects read, and bits 6:0 give the start address.
- R2: The trailing SCLK edge is the return to the level SCLK had when cs rose. MOSI is sampled on trailing edges, and miso changes only after leading edges. SCLK idle low and SCLK idle high are both supported. miso is 0 while cs is low and during the command byte.
- R3: Successive data bytes use successive addresses, and the address wraps from 0x7F to 0x00.
- R4: An accepted write to 0x00–0x0E or 0x10 produces a single-cycle ext_wr_en pulse carrying the address and data. No other address ever pulses ext_wr_en.
- R5: The control register at 0x0F resets to 0x40. Bit 7 is the oscillator-off flag and bit 6 is the write lock. Bits 5:3 always read 0, and the other bits hold what was written.
- R6: While control bit 6 is 1, a write to any address other than 0x0F is ignored: nothing is forwarded, and RAM and the charger setting keep their values.
- R7: A read of 0x10 returns {6'b0, irq_flags}.
- R8: The charger register at 0x11 resets to 0x00. A write is stored only when data bits 7:4 equal 4'b1010; any other write leaves it unchanged.
- R9: Addresses 0x12–0x1F read as 0x00, and writes to them have no effect.
- R10: Addresses 0x20–0x7F are a 96-byte RAM that resets to 0x00 and reads back what was written.
- R11: A read returns, for bytes 0x00–0x06, the value time_now had when its command byte completed, even if time_now changes later in the transaction. Bytes 0x07–0x0E return alarm_now directly (byte n at bits 8(n-7)+7 : 8(n-7)). Time byte n is at time_now bits 8n+7 : 8n.
- R12: If cs falls in the middle of a byte, that partial byte is discarded, and the next transaction starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs | input | 1 | Active-high select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| time_now | input | 56 | Live time bytes 0x00–0x06 |
| alarm_now | input | 64 | Live alarm bytes 0x07–0x0E |
| irq_flags | input | 2 | Alarm flags read at 0x10 |
| ext_wr_en | output | 1 | Forwarded-write strobe |
| ext_wr_addr | output | 5 | Forwarded-write address |
| ext_wr_data | output | 8 | Forwarded-write data |
| ctrl_q | output | 8 | Control register contents |
| trickle_q | output | 8 | Charger setting contents |

## Verification
Transfers are driven with both clock idle levels. Single-byte and burst transactions are used, so an error in edge selection shows up as shifted bits in only one polarity. Burst writes and reads cross the 0x7F-to-0x00 wrap and the region edges (status, charger, hole, RAM); this separates a stepping error from a decoding error. Writes are issued both with the lock set and with it clear, and the charger is written with both matching and non-matching keys. The time input is changed in the middle of a read, which distinguishes a snapshot from a live read, and select is dropped mid-byte to show that partial bytes leave no trace.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int BYTE_W = 8;
  localparam int AW = 7;
  localparam int TIME_N = 7;
  localparam int ALRM_N = 8;
  localparam int STAT_W = 2;
  localparam int EXT_AW = 5;
  localparam logic [AW-1:0] A_CTRL = 7'h0F;
  localparam logic [AW-1:0] A_STAT = 7'h10;
  localparam logic [AW-1:0] A_TRKL = 7'h11;
  localparam logic [AW-1:0] A_RAM0 = 7'h20;
  localparam logic [3:0] TRKL_KEY = 4'b1010;
  localparam logic [BYTE_W-1:0] CTRL_RST = 8'h40;
  localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'hC7;
  localparam int CTRL_WP_BIT = 6;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;
  typedef enum logic [2:0] {RG_TIME, RG_ALRM, RG_CTRL, RG_STAT, RG_TRKL, RG_HOLE, RG_RAM} region_e;

  function automatic region_e classify(input logic [AW-1:0] a);
    if (a < AW'(TIME_N)) return RG_TIME;
    else if (a < A_CTRL) return RG_ALRM;
    else if (a == A_CTRL) return RG_CTRL;
    else if (a == A_STAT) return RG_STAT;
    else if (a == A_TRKL) return RG_TRKL;
    else if (a < A_RAM0) return RG_HOLE;
    else return RG_RAM;
  endfunction

  function automatic logic forwards(input logic [AW-1:0] a);
    region_e r;
    r = classify(a);
    return (r == RG_TIME) || (r == RG_ALRM) || (r == RG_STAT);
  endfunction

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [BYTE_W-1:0] ctrl_merge(input logic [BYTE_W-1:0] d);
    return d & CTRL_KEEP;
  endfunction

  function automatic logic trkl_ok(input logic [BYTE_W-1:0] d);
    return d[BYTE_W-1 -: 4] == TRKL_KEY;
  endfunction
endpackage

// File: rtl/spi_rf_link.sv
module spi_rf_link #(
  parameter int BITS = 8,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            cs,
  input  logic            mosi,
  input  logic            tx_load,
  input  logic [BITS-1:0] tx_data,
  output logic            sel,
  output logic            lead,
  output logic            trail,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte,
  output logic            miso
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [SYNC-1:0] sclk_p, cs_p, mosi_p;
  logic sclk_s, cs_s, mosi_s, sclk_d, cs_d, idle_q, edge_w;
  logic [CW-1:0] cnt_q;
  logic [BITS-2:0] rx_sr;
  logic [BITS-1:0] tx_sr, rxb_q;
  logic done_q, miso_q;

  assign sclk_s = sclk_p[SYNC-1];
  assign cs_s   = cs_p[SYNC-1];
  assign mosi_s = mosi_p[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '0;
      mosi_p <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[SYNC-2:0], sclk};
      cs_p   <= {cs_p[SYNC-2:0], cs};
      mosi_p <= {mosi_p[SYNC-2:0], mosi};
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign sel    = cs_s;
  assign edge_w = cs_s & cs_d & (sclk_s ^ sclk_d);
  assign lead   = edge_w & (sclk_d == idle_q);
  assign trail  = edge_w & (sclk_s == idle_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      cnt_q  <= '0;
      rx_sr  <= '0;
      done_q <= 1'b0;
      rxb_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (cs_s & ~cs_d) idle_q <= sclk_s;
      if (!cs_s) begin
        cnt_q <= '0;
      end else if (trail) begin
        rx_sr <= {rx_sr[BITS-3:0], mosi_s};
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
          rxb_q  <= {rx_sr, mosi_s};
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr  <= '0;
      miso_q <= 1'b0;
    end else if (!cs_s) begin
      tx_sr  <= '0;
      miso_q <= 1'b0;
    end else if (tx_load) begin
      tx_sr <= tx_data;
    end else if (lead) begin
      miso_q <= tx_sr[BITS-1];
      tx_sr  <= {tx_sr[BITS-2:0], 1'b0};
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = rxb_q;
  assign miso      = miso_q;
endmodule

// File: rtl/spi_rf_seq.sv
module spi_rf_seq
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [AW-1:0]     addr,
  output logic              in_data,
  output logic              wr_req,
  output logic              snap_en,
  output logic              tx_load
);
  phase_e phase_q;
  logic [AW-1:0] addr_q;
  logic wmode_q, ld_q;

  assign in_data = (phase_q == PH_DATA);
  assign wr_req  = sel & byte_done & in_data & wmode_q;
  assign snap_en = sel & byte_done & ~in_data & ~rx_byte[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      addr_q  <= '0;
      wmode_q <= 1'b0;
      ld_q    <= 1'b0;
    end else if (!sel) begin
      phase_q <= PH_CMD;
      ld_q    <= 1'b0;
    end else if (byte_done) begin
      if (phase_q == PH_CMD) begin
        addr_q  <= rx_byte[AW-1:0];
        wmode_q <= rx_byte[BYTE_W-1];
        phase_q <= PH_DATA;
        ld_q    <= ~rx_byte[BYTE_W-1];
      end else begin
        addr_q <= step_addr(addr_q);
        ld_q   <= ~wmode_q;
      end
    end else begin
      ld_q <= 1'b0;
    end
  end

  assign addr    = addr_q;
  assign tx_load = ld_q;
endmodule

// File: rtl/spi_rf_store.sv
module spi_rf_store
  import spi_rf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     snap_en,
  input  logic [TIME_N*BYTE_W-1:0] time_now,
  input  logic [ALRM_N*BYTE_W-1:0] alarm_now,
  input  logic [STAT_W-1:0]        irq_flags,
  input  logic                     wr_req,
  input  logic [AW-1:0]            wr_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic [AW-1:0]            rd_addr,
  output logic [BYTE_W-1:0]        rd_data,
  output logic                     wr_accept,
  output logic                     ext_wr_en,
  output logic [EXT_AW-1:0]        ext_wr_addr,
  output logic [BYTE_W-1:0]        ext_wr_data,
  output logic [BYTE_W-1:0]        ctrl_q,
  output logic [BYTE_W-1:0]        trkl_q
);
  localparam int RAM_D = (1 << AW) - int'(A_RAM0);
  localparam int RIW = $clog2(RAM_D);

  logic [BYTE_W-1:0] ram [RAM_D];
  logic [TIME_N*BYTE_W-1:0] snap_q;
  logic [BYTE_W-1:0] ctrl_r, trkl_r;
  logic [RIW-1:0] widx, ridx;
  logic [AW-1:0] aoff;
  logic locked;
  region_e wreg, rreg;
  logic fwd_q;
  logic [EXT_AW-1:0] fa_q;
  logic [BYTE_W-1:0] fd_q;

  assign locked    = ctrl_r[CTRL_WP_BIT];
  assign wreg      = classify(wr_addr);
  assign rreg      = classify(rd_addr);
  assign wr_accept = wr_req & ((wr_addr == A_CTRL) | ~locked);
  assign widx      = RIW'(wr_addr - A_RAM0);
  assign ridx      = RIW'(rd_addr - A_RAM0);
  assign aoff      = rd_addr - AW'(TIME_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= CTRL_RST;
      trkl_r <= '0;
      snap_q <= '0;
      fwd_q  <= 1'b0;
      fa_q   <= '0;
      fd_q   <= '0;
      for (int i = 0; i < RAM_D; i++) ram[i] <= '0;
    end else begin
      fwd_q <= wr_accept & forwards(wr_addr);
      if (wr_accept) begin
        fa_q <= wr_addr[EXT_AW-1:0];
        fd_q <= wr_data;
      end
      if (snap_en) snap_q <= time_now;
      if (wr_accept && wreg == RG_CTRL) ctrl_r <= ctrl_merge(wr_data);
      if (wr_accept && wreg == RG_TRKL && trkl_ok(wr_data)) trkl_r <= wr_data;
      if (wr_accept && wreg == RG_RAM) ram[widx] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rreg)
      RG_TIME: begin
        for (int i = 0; i < TIME_N; i++)
          if (rd_addr == AW'(i)) rd_data = snap_q[i*BYTE_W +: BYTE_W];
      end
      RG_ALRM: begin
        for (int i = 0; i < ALRM_N; i++)
          if (aoff == AW'(i)) rd_data = alarm_now[i*BYTE_W +: BYTE_W];
      end
      RG_CTRL: rd_data = ctrl_r;
      RG_STAT: rd_data = {{(BYTE_W-STAT_W){1'b0}}, irq_flags};
      RG_TRKL: rd_data = trkl_r;
      RG_RAM:  rd_data = ram[ridx];
      default: rd_data = '0;
    endcase
  end

  assign ext_wr_en   = fwd_q;
  assign ext_wr_addr = fa_q;
  assign ext_wr_data = fd_q;
  assign ctrl_q      = ctrl_r;
  assign trkl_q      = trkl_r;
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spi_rf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk,
  input  logic                     cs,
  input  logic                     mosi,
  output logic                     miso,
  input  logic [TIME_N*BYTE_W-1:0] time_now,
  input  logic [ALRM_N*BYTE_W-1:0] alarm_now,
  input  logic [STAT_W-1:0]        irq_flags,
  output logic                     ext_wr_en,
  output logic [EXT_AW-1:0]        ext_wr_addr,
  output logic [BYTE_W-1:0]        ext_wr_data,
  output logic [BYTE_W-1:0]        ctrl_q,
  output logic [BYTE_W-1:0]        trickle_q
);
  logic sel_w, lead_w, trail_w, byte_done_w, tx_load_w;
  logic in_data_w, wr_req_w, snap_en_w, wr_accept_w;
  logic [BYTE_W-1:0] rx_byte_w, rd_data_w;
  logic [AW-1:0] addr_w;

  spi_rf_link #(.BITS(BYTE_W), .SYNC(SYNC_STAGES)) link_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs), .mosi(mosi),
    .tx_load(tx_load_w), .tx_data(rd_data_w),
    .sel(sel_w), .lead(lead_w), .trail(trail_w), .byte_done(byte_done_w),
    .rx_byte(rx_byte_w), .miso(miso)
  );

  spi_rf_seq seq_i (
    .clk(clk), .rst_n(rst_n), .sel(sel_w), .byte_done(byte_done_w), .rx_byte(rx_byte_w),
    .addr(addr_w), .in_data(in_data_w), .wr_req(wr_req_w), .snap_en(snap_en_w),
    .tx_load(tx_load_w)
  );

  spi_rf_store store_i (
    .clk(clk), .rst_n(rst_n), .snap_en(snap_en_w), .time_now(time_now),
    .alarm_now(alarm_now), .irq_flags(irq_flags), .wr_req(wr_req_w), .wr_addr(addr_w),
    .wr_data(rx_byte_w), .rd_addr(addr_w), .rd_data(rd_data_w), .wr_accept(wr_accept_w),
    .ext_wr_en(ext_wr_en), .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data),
    .ctrl_q(ctrl_q), .trkl_q(trickle_q)
  );
endmodule

// File: rtl/spi_regfile_slave_chk.sv
module spi_regfile_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       lead,
  input logic       trail,
  input logic       miso,
  input logic       byte_done,
  input logic       in_data,
  input logic       wr_accept,
  input logic [6:0] addr,
  input logic       ext_wr_en,
  input logic [4:0] ext_wr_addr,
  input logic [7:0] ctrl_q,
  input logic [7:0] trickle_q
);
  a_r2_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso);
  a_r2_miso_on_lead: assert property (@(posedge clk) disable iff (!rst_n)
    sel && !lead |=> $stable(miso));
  a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead && trail));
  a_r1_cmd_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && sel && !in_data |=> in_data);
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && sel && in_data |=> addr == 7'($past(addr) + 7'd1));
  a_r4_ext_single: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_en |=> !ext_wr_en);
  a_r4_ext_range: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_en |-> (ext_wr_addr < 5'd15 || ext_wr_addr == 5'd16));
  a_r4_ext_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_en |-> $past(wr_accept));
  a_r6_locked_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_en |-> !ctrl_q[6]);
  a_r5_ctrl_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[5:3] == 3'b000);
  a_r8_trickle_key: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trickle_q) |-> trickle_q[7:4] == 4'b1010);
endmodule

bind spi_regfile_slave spi_regfile_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel_w), .lead(lead_w), .trail(trail_w), .miso(miso),
  .byte_done(byte_done_w), .in_data(in_data_w), .wr_accept(wr_accept_w), .addr(addr_w),
  .ext_wr_en(ext_wr_en), .ext_wr_addr(ext_wr_addr), .ctrl_q(ctrl_q), .trickle_q(trickle_q)
);

// File: tb/spi_regfile_slave_tb.sv
module spi_regfile_slave_tb_top;
  localparam int CLK_NS = 10;
  localparam int HALF = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs = 1'b0;
  logic mosi = 1'b0;
  logic [55:0] time_now;
  logic [63:0] alarm_now;
  logic [1:0] irq_flags;
  wire miso, ext_wr_en;
  wire [4:0] ext_wr_addr;
  wire [7:0] ext_wr_data, ctrl_q, trickle_q;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  int cs_low_cnt = 0;
  int alt_after = -1;
  logic [55:0] time_alt;
  logic [7:0] m_ram [128];
  logic [7:0] m_ctrl, m_trkl;
  logic [55:0] m_snap;
  logic [12:0] exp_q[$];
  logic [12:0] got_w;
  logic [7:0] tx_q[$];

  always #(CLK_NS/2) clk = ~clk;

  spi_regfile_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs), .mosi(mosi), .miso(miso),
    .time_now(time_now), .alarm_now(alarm_now), .irq_flags(irq_flags),
    .ext_wr_en(ext_wr_en), .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data),
    .ctrl_q(ctrl_q), .trickle_q(trickle_q)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mread(input logic [6:0] a);
    int ai;
    ai = int'(a);
    if (ai < 7) return m_snap[ai*8 +: 8];
    else if (ai < 15) return alarm_now[(ai-7)*8 +: 8];
    else if (ai == 15) return m_ctrl;
    else if (ai == 16) return {6'b0, irq_flags};
    else if (ai == 17) return m_trkl;
    else if (ai < 32) return 8'h00;
    else return m_ram[ai];
  endfunction

  function automatic void mwrite(input logic [6:0] a, input logic [7:0] d);
    int ai;
    ai = int'(a);
    if (ai != 15 && m_ctrl[6]) return;
    if (ai < 15 || ai == 16) exp_q.push_back({a[4:0], d});
    else if (ai == 15) m_ctrl = d & 8'hC7;
    else if (ai == 17) begin
      if (d[7:4] == 4'hA) m_trkl = d;
    end else if (ai >= 32) m_ram[ai] = d;
  endfunction

  // sends tx_q, then part_bits bits of an abandoned byte; checks read data
  task automatic xact(input bit cpol, input int part_bits, input string req);
    logic [7:0] b, r, e;
    logic [6:0] a;
    bit wr;
    int n;
    a = '0;
    wr = 1'b0;
    sclk = cpol;
    repeat (4) @(negedge clk);
    cs = 1'b1;
    repeat (HALF) @(negedge clk);
    n = tx_q.size();
    for (int i = 0; i < n; i++) begin
      b = tx_q[i];
      e = 8'h00;
      if (i == 0) begin
        a = b[6:0];
        wr = b[7];
        if (!wr) m_snap = time_now;
      end else if (wr) mwrite(a, b);
      else e = mread(a);
      for (int k = 7; k >= 0; k--) begin
        sclk = ~cpol;
        mosi = b[k];
        repeat (HALF) @(negedge clk);
        r[k] = miso;
        sclk = cpol;
        repeat (HALF) @(negedge clk);
      end
      if (i > 0 && !wr) check(req, r, e);
      if (i > 0) a = a + 7'd1;
      if (i == alt_after) time_now = time_alt;
    end
    for (int k = 0; k < part_bits; k++) begin
      sclk = ~cpol;
      mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = cpol;
      repeat (HALF) @(negedge clk);
    end
    cs = 1'b0;
    mosi = 1'b0;
    repeat (2*HALF) @(negedge clk);
    check({req, " R4 pending forwards"}, exp_q.size(), 0);
    check({req, " R5 ctrl"}, ctrl_q, m_ctrl);
    check({req, " R8 trickle"}, trickle_q, m_trkl);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (ext_wr_en) begin
        vectors++;
        if (exp_q.size() == 0) begin
          miscompares++;
          $display("FAIL R4/R6 forward: actual %0h expected none", {ext_wr_addr, ext_wr_data});
        end else begin
          got_w = exp_q.pop_front();
          if (got_w !== {ext_wr_addr, ext_wr_data}) begin
            miscompares++;
            $display("FAIL R4 forward: actual %0h expected %0h", {ext_wr_addr, ext_wr_data}, got_w);
          end
        end
      end
      if (cs) cs_low_cnt = 0;
      else cs_low_cnt++;
      if (cs_low_cnt > 4) begin
        vectors++;
        if (miso !== 1'b0) begin
          miscompares++;
          $display("FAIL R2 idle miso: actual %0b expected 0", miso);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    time_now = 56'h23_11_09_04_15_42_30;
    alarm_now = 64'h80_80_81_00_07_06_05_04;
    irq_flags = 2'b00;
    time_alt = 56'h99_88_77_66_55_44_33;
    m_ctrl = 8'h40;
    m_trkl = 8'h00;
    for (int i = 0; i < 128; i++) m_ram[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 reset ctrl", ctrl_q, 8'h40);
    check("R8 reset trickle", trickle_q, 8'h00);
    check("R2 reset miso", miso, 1'b0);

    tx_q = '{8'h0F, 8'h00};               xact(1'b0, 0, "R1 read ctrl");
    // R6: lock set from reset
    tx_q = '{8'hA0, 8'h11};               xact(1'b0, 0, "R6 ram locked");
    tx_q = '{8'h80, 8'h12};               xact(1'b1, 0, "R6 time locked");
    tx_q = '{8'h91, 8'hA3};               xact(1'b0, 0, "R6 trickle locked");
    tx_q = '{8'h20, 8'h00};               xact(1'b0, 0, "R6 ram unchanged");
    // R5: control writes and masked bits
    tx_q = '{8'h8F, 8'h00};               xact(1'b0, 0, "R5 unlock");
    tx_q = '{8'h8F, 8'hFF};               xact(1'b1, 0, "R5 ctrl all ones");
    tx_q = '{8'h0F, 8'h00};               xact(1'b1, 0, "R5 ctrl readback");
    tx_q = '{8'h8F, 8'hBF};               xact(1'b0, 0, "R5 ctrl osc off");
    // R10 R3 R2: burst in idle-high, readback in idle-low
    tx_q = '{8'hA0, 8'h01, 8'h02, 8'h03, 8'h04};  xact(1'b1, 0, "R10 ram burst write");
    tx_q = '{8'h20, 8'h00, 8'h00, 8'h00, 8'h00};  xact(1'b0, 0, "R10 R3 ram burst read");
    tx_q = '{8'h20, 8'h00, 8'h00};                xact(1'b1, 0, "R2 idle-high read");
    // R3 wrap
    tx_q = '{8'hFE, 8'h5A, 8'hA5, 8'h33}; xact(1'b0, 0, "R3 wrap write");
    tx_q = '{8'h7F, 8'h00, 8'h00};        xact(1'b1, 0, "R3 wrap read");
    // R4 forwards
    tx_q = '{8'h80, 8'h21, 8'h22};        xact(1'b0, 0, "R4 time write");
    tx_q = '{8'h8D, 8'h44, 8'h55};        xact(1'b1, 0, "R4 alarm write");
    tx_q = '{8'h90, 8'h00};               xact(1'b0, 0, "R4 status write");
    // R8 key
    tx_q = '{8'h91, 8'h35};               xact(1'b0, 0, "R8 bad key");
    tx_q = '{8'h91, 8'hA5};               xact(1'b1, 0, "R8 good key");
    tx_q = '{8'h11, 8'h00};               xact(1'b0, 0, "R8 trickle read");
    // R7 status, R9 holes
    irq_flags = 2'b10;
    tx_q = '{8'h10, 8'h00};               xact(1'b0, 0, "R7 status read");
    irq_flags = 2'b01;
    tx_q = '{8'h10, 8'h00, 8'h00, 8'h00, 8'h00};  xact(1'b1, 0, "R7 R9 status burst");
    tx_q = '{8'h92, 8'h55, 8'h66};        xact(1'b0, 0, "R9 hole write");
    tx_q = '{8'h12, 8'h00, 8'h00};        xact(1'b0, 0, "R9 hole read");
    tx_q = '{8'h1F, 8'h00, 8'h00};        xact(1'b1, 0, "R9 hole to ram");
    // R11 snapshot and live alarm
    alt_after = 1;
    tx_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    xact(1'b0, 0, "R11 snapshot");
    alt_after = -1;
    tx_q = '{8'h00, 8'h00};               xact(1'b1, 0, "R11 new time");
    tx_q = '{8'h07, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    xact(1'b0, 0, "R11 alarm read");
    alarm_now = 64'h01_02_03_04_05_06_07_08;
    tx_q = '{8'h0B, 8'h00, 8'h00};        xact(1'b1, 0, "R11 alarm live");
    // R12 aborts
    tx_q = '{8'hA0};                      xact(1'b0, 5, "R12 abort data");
    tx_q = '{8'h20, 8'h00};               xact(1'b0, 0, "R12 ram intact");
    tx_q.delete();                        xact(1'b1, 3, "R12 abort cmd");
    tx_q = '{8'h0F, 8'h00};               xact(1'b1, 0, "R12 fresh cmd");
    // R6 relock
    tx_q = '{8'h8F, 8'h40};               xact(1'b0, 0, "R6 relock");
    tx_q = '{8'hA1, 8'h99};               xact(1'b0, 0, "R6 ram blocked");
    tx_q = '{8'h91, 8'hA7};               xact(1'b1, 0, "R6 trickle blocked");
    tx_q = '{8'h8C, 8'h77};               xact(1'b0, 0, "R6 alarm blocked");
    tx_q = '{8'h21, 8'h00};               xact(1'b1, 0, "R6 ram kept");
    tx_q = '{8'h8F, 8'h00};               xact(1'b0, 0, "R6 unlock again");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule